// File: doc/BRIEF.md
# Processor Hotplug Presence Register Block

This block keeps a presence bitmap for up to 256 processors and signals a system control interrupt whenever a processor is brought in or taken out. Firmware reads the bitmap as a run of bytes at a fixed I/O window. It reads and clears a small event status byte and programs an event enable byte. Together these two bytes decide whether the interrupt line is asserted.

A platform agent reports hotplug activity on a one-cycle event port. The port carries a processor number and an add/remove flag. Each accepted event updates that processor's presence bit and latches the shared processor-event status bit. A separate device-hotplug strobe latches its own status bit. The interrupt is a level that is recomputed from the status, the enable and a set of already-pending fixed power-management events. At reset the bitmap is loaded so that the first `CPU_COUNT` processors read as present.

Top module: `cpuhp_regs`

## Requirements
- R1: A read at address 0xAF00+n (0 ≤ n < 32) returns bitmap byte n. Processor k occupies byte k/8, bit k%8.
- R2: After reset the bitmap holds processors 0..CPU_COUNT-1 as present. Full groups of eight read 0xFF, a partial group of r reads (1<<r)-1, and higher bytes read 0x00.
- R3: An accepted add event sets the processor's bit, visible on reads from the cycle after the event.
- R4: An accepted remove event clears the processor's bit, visible from the cycle after the event.
- R5: Every accepted add or remove event sets status bit 2 (value 0x04). The status byte is read at 0xAFE0.
- R6: A device-hotplug strobe sets status bit 1 (value 0x02).
- R7: Writing the status byte clears each bit written as 1 and leaves the others. Writing the enable byte at 0xAFE1 stores the value, which reads back at the same address.
- R8: `sci` is high exactly when (status AND enable) has bit 1 or bit 2 set, or when some fixed event is both pending and enabled.
- R9: Writes into the bitmap window leave the bitmap unchanged. Reads of any address outside the bitmap, status and enable locations return 0x00.
- R10: An event whose processor number is 256 or more changes neither the bitmap nor the status byte.
- R11: When a status clear and an accepted processor event fall in the same cycle, status bit 2 ends up set.
- R12: Reset clears the status and enable bytes, so `sci` is low afterwards while no fixed event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O byte address for reads and writes |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| plug_valid | input | 1 | Processor hotplug event strobe |
| plug_index | input | 9 | Processor number of the event |
| plug_add | input | 1 | 1 = processor added, 0 = removed |
| dev_event | input | 1 | Device hotplug event strobe |
| fixed_sts | input | 3 | Pending fixed power-management events |
| fixed_en | input | 3 | Enables for the fixed events |
| sci | output | 1 | System control interrupt level |

## Verification
The assertions assume that `plug_valid` and `dev_event` are single-cycle strobes sampled on the clock. They also assume that `plug_index` and `plug_add` are stable while `plug_valid` is high, and that a status write and an event may share a cycle. The stimulus drives every input half a cycle away from the active edge and holds each strobe for exactly one cycle. Each read is taken after its address has settled, so every read reflects state committed at the previous edge. Out-of-range processor numbers are driven on purpose. Because their low bits alias a real bitmap position, the ignore rule is visible through the ordinary read port.

// File: rtl/cpuhp_pkg.sv
// Package: shared constants for the processor hotplug register block.
// Assumes byte-wide I/O and an eight-bit event status/enable pair.
package cpuhp_pkg;
    localparam int STS_DEV_BIT = 1;     // device hotplug status position
    localparam int STS_CPU_BIT = 2;     // processor hotplug status position
    localparam logic [7:0] STS_SCI_MASK = 8'h06;
endpackage

// File: rtl/cpuhp_presence.sv
// Module: per-processor presence bitmap.
// Holds one bit per processor, loads the first CPU_COUNT bits on reset,
// and sets or clears a bit on each in-range hotplug event.
// Assumes evt_valid is a one-cycle strobe with stable index and flag.
module cpuhp_presence #(
    parameter int MAX_CPUS  = 256,
    parameter int CPU_COUNT = 13,
    parameter int IDX_W     = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [IDX_W-1:0]    evt_index,
    input  logic                evt_add,
    output logic [MAX_CPUS-1:0] present,
    output logic                evt_taken
);
    localparam int SEL_W = $clog2(MAX_CPUS);

    logic [SEL_W-1:0] sel;
    logic             in_range;

    // Purpose: qualify the event against the number of tracked processors.
    always_comb begin
        in_range  = (evt_index < IDX_W'(MAX_CPUS));
        evt_taken = evt_valid && in_range;
        sel       = evt_index[SEL_W-1:0];
    end

    // Purpose: reset fill and per-event bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_CPUS; k++) begin
                present[k] <= (k < CPU_COUNT);
            end
        end else if (evt_taken) begin
            present[sel] <= evt_add;
        end
    end

    AST_ADD_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_taken && evt_add) |=> present[$past(sel)]);            // R3
    AST_REMOVE_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_taken && !evt_add) |=> !present[$past(sel)]);          // R4
    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !in_range) |=> $stable(present));             // R10
endmodule

// File: rtl/cpuhp_gpe.sv
// Module: event status/enable pair and interrupt level.
// Status bits are set by hardware events and cleared by writing ones;
// a same-cycle set beats the clear. Enable is a plain stored byte.
// Assumes cpu_evt and dev_evt are one-cycle strobes.
module cpuhp_gpe #(
    parameter int FIX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_evt,
    input  logic             dev_evt,
    input  logic             sts_wr,
    input  logic             en_wr,
    input  logic [7:0]       wdata,
    input  logic [FIX_W-1:0] fixed_sts,
    input  logic [FIX_W-1:0] fixed_en,
    output logic [7:0]       sts,
    output logic [7:0]       en,
    output logic             sci
);
    import cpuhp_pkg::*;

    logic [7:0] set_vec;
    logic [7:0] clr_vec;

    // Purpose: build the set and clear masks for this cycle.
    always_comb begin
        set_vec              = '0;
        set_vec[STS_CPU_BIT] = cpu_evt;
        set_vec[STS_DEV_BIT] = dev_evt;
        clr_vec              = sts_wr ? wdata : 8'h00;
    end

    // Purpose: status register, write-one-to-clear with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~clr_vec) | set_vec;
    end

    // Purpose: enable register, direct store.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_wr) en <= wdata;
    end

    // Purpose: interrupt level from masked general and fixed sources.
    always_comb begin
        sci = (|(sts & en & STS_SCI_MASK)) || (|(fixed_sts & fixed_en));
    end

    AST_CPU_STS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_evt |=> sts[STS_CPU_BIT]);                              // R5
    AST_DEV_STS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dev_evt |=> sts[STS_DEV_BIT]);                              // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && wdata[STS_CPU_BIT] && !cpu_evt) |=> !sts[STS_CPU_BIT]); // R7
    AST_EN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en == $past(wdata)));                            // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && cpu_evt) |=> sts[STS_CPU_BIT]);                  // R11
endmodule

// File: rtl/cpuhp_iodec.sv
// Module: I/O address decode and read multiplexer.
// Maps the bitmap bytes, the status byte and the enable byte into
// the I/O space; other addresses read zero. Bitmap writes are dropped.
// Assumes reads are combinational on io_addr.
module cpuhp_iodec #(
    parameter logic [15:0] BASE_ADDR = 16'hAF00,
    parameter logic [15:0] STS_ADDR  = 16'hAFE0,
    parameter logic [15:0] EN_ADDR   = 16'hAFE1,
    parameter int          NBYTES    = 32
) (
    input  logic [15:0]         io_addr,
    input  logic                io_wr,
    input  logic [NBYTES*8-1:0] present,
    input  logic [7:0]          sts,
    input  logic [7:0]          en,
    output logic [7:0]          rdata,
    output logic                sts_wr,
    output logic                en_wr
);
    localparam int OFF_W = $clog2(NBYTES);

    logic [7:0]  bytes [NBYTES];
    logic [15:0] off;
    logic        in_map;

    // Purpose: split the flat bitmap into addressable bytes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign bytes[g] = present[g*8 +: 8];
    end

    // Purpose: decode the window and pick read data.
    always_comb begin
        off    = io_addr - BASE_ADDR;
        in_map = (io_addr >= BASE_ADDR) && (off < 16'(NBYTES));
        if (in_map)                rdata = bytes[off[OFF_W-1:0]];
        else if (io_addr == STS_ADDR) rdata = sts;
        else if (io_addr == EN_ADDR)  rdata = en;
        else                       rdata = 8'h00;
    end

    // Purpose: write strobes for the two writable locations only.
    always_comb begin
        sts_wr = io_wr && (io_addr == STS_ADDR);
        en_wr  = io_wr && (io_addr == EN_ADDR);
    end
endmodule

// File: rtl/cpuhp_regs.sv
// Module: top of the processor hotplug register block.
// Connects the presence bitmap, the event status/enable pair and the
// I/O decoder. Assumes one clock domain and synchronous reset.
module cpuhp_regs #(
    parameter int          MAX_CPUS  = 256,
    parameter int          CPU_COUNT = 13,
    parameter int          FIX_W     = 3,
    parameter logic [15:0] BASE_ADDR = 16'hAF00,
    parameter logic [15:0] STS_ADDR  = 16'hAFE0,
    parameter logic [15:0] EN_ADDR   = 16'hAFE1,
    localparam int         IDX_W     = $clog2(MAX_CPUS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      io_addr,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic             plug_valid,
    input  logic [IDX_W-1:0] plug_index,
    input  logic             plug_add,
    input  logic             dev_event,
    input  logic [FIX_W-1:0] fixed_sts,
    input  logic [FIX_W-1:0] fixed_en,
    output logic             sci
);
    localparam int NBYTES = MAX_CPUS / 8;

    logic [MAX_CPUS-1:0] present;
    logic                cpu_evt;
    logic [7:0]          sts;
    logic [7:0]          en;
    logic                sts_wr;
    logic                en_wr;

    cpuhp_presence #(
        .MAX_CPUS (MAX_CPUS),
        .CPU_COUNT(CPU_COUNT),
        .IDX_W    (IDX_W)
    ) u_presence (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(plug_valid),
        .evt_index(plug_index),
        .evt_add  (plug_add),
        .present  (present),
        .evt_taken(cpu_evt)
    );

    cpuhp_gpe #(
        .FIX_W(FIX_W)
    ) u_gpe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_evt  (cpu_evt),
        .dev_evt  (dev_event),
        .sts_wr   (sts_wr),
        .en_wr    (en_wr),
        .wdata    (io_wdata),
        .fixed_sts(fixed_sts),
        .fixed_en (fixed_en),
        .sts      (sts),
        .en       (en),
        .sci      (sci)
    );

    cpuhp_iodec #(
        .BASE_ADDR(BASE_ADDR),
        .STS_ADDR (STS_ADDR),
        .EN_ADDR  (EN_ADDR),
        .NBYTES   (NBYTES)
    ) u_iodec (
        .io_addr(io_addr),
        .io_wr  (io_wr),
        .present(present),
        .sts    (sts),
        .en     (en),
        .rdata  (io_rdata),
        .sts_wr (sts_wr),
        .en_wr  (en_wr)
    );

    AST_SCI_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !(|(fixed_sts & fixed_en))) |-> !sci);     // R12
endmodule

// File: tb/cpuhp_regs_bench.sv
module cpuhp_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        plug_valid = 1'b0;
    logic [8:0]  plug_index = '0;
    logic        plug_add = 1'b0;
    logic        dev_event = 1'b0;
    logic [2:0]  fixed_sts = '0;
    logic [2:0]  fixed_en = '0;
    logic        sci;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpuhp_regs u_cpuhp_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .plug_valid(plug_valid),
        .plug_index(plug_index), .plug_add(plug_add), .dev_event(dev_event),
        .fixed_sts(fixed_sts), .fixed_en(fixed_en), .sci(sci)
    );

    // op: 0 read-check, 1 add, 2 remove, 3 write
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] arg;
        logic [7:0]  dat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'hAF00, 8'hFF, 4'd2},   // R2 full group
        '{2'd0, 16'hAF01, 8'h1F, 4'd2},   // R2 partial group of 5
        '{2'd0, 16'hAF02, 8'h00, 4'd2},   // R2 empty byte
        '{2'd0, 16'hAF1F, 8'h00, 4'd2},   // R2 last byte
        '{2'd0, 16'hAFE0, 8'h00, 4'd12},  // R12 status reset
        '{2'd0, 16'hAFE1, 8'h00, 4'd12},  // R12 enable reset
        '{2'd1, 16'd20,   8'h00, 4'd3},   // R3 add processor 20
        '{2'd0, 16'hAF02, 8'h10, 4'd1},   // R1 byte 2 bit 4
        '{2'd0, 16'hAFE0, 8'h04, 4'd5},   // R5 status bit 2
        '{2'd2, 16'd3,    8'h00, 4'd4},   // R4 remove processor 3
        '{2'd0, 16'hAF00, 8'hF7, 4'd4},   // R4
        '{2'd3, 16'hAFE0, 8'h04, 4'd7},   // R7 clear status
        '{2'd0, 16'hAFE0, 8'h00, 4'd7},   // R7
        '{2'd1, 16'd255,  8'h00, 4'd1},   // R1 top processor
        '{2'd0, 16'hAF1F, 8'h80, 4'd1},   // R1
        '{2'd3, 16'hAF00, 8'h00, 4'd9},   // R9 bitmap write ignored
        '{2'd0, 16'hAF00, 8'hF7, 4'd9}    // R9
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = a;
        #1;
        check(io_rdata, exp, req);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic evt(input int idx, input bit add);
        @(negedge clk);
        plug_valid = 1'b1; plug_index = 9'(idx); plug_add = add;
        @(negedge clk);
        plug_valid = 1'b0;
    endtask

    task automatic chk_sci(input logic exp, input string req);
        #1;
        check({7'd0, sci}, {7'd0, exp}, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: rd(VECS[i].arg, VECS[i].dat, $sformatf("R%0d vec%0d", VECS[i].req, i));
                2'd1: evt(int'(VECS[i].arg), 1'b1);
                2'd2: evt(int'(VECS[i].arg), 1'b0);
                default: wr(VECS[i].arg, VECS[i].dat);
            endcase
        end
        // R9 unmapped read
        rd(16'h1234, 8'h00, "R9 unmapped");
        rd(16'hAF20, 8'h00, "R9 past window");
        // R7 enable store, R8 interrupt level (status holds 0x04 from add 255)
        wr(16'hAFE1, 8'h06);
        rd(16'hAFE1, 8'h06, "R7 enable readback");
        chk_sci(1'b1, "R8 cpu source");
        wr(16'hAFE0, 8'h04);
        chk_sci(1'b0, "R8 after clear");
        // R6 device event
        @(negedge clk); dev_event = 1'b1;
        @(negedge clk); dev_event = 1'b0;
        rd(16'hAFE0, 8'h02, "R6 dev status");
        chk_sci(1'b1, "R8 dev source");
        wr(16'hAFE1, 8'h04);
        chk_sci(1'b0, "R8 dev masked");
        wr(16'hAFE0, 8'h02);
        // R8 fixed events
        @(negedge clk); fixed_sts = 3'b010; fixed_en = 3'b001;
        chk_sci(1'b0, "R8 fixed not enabled");
        @(negedge clk); fixed_en = 3'b010;
        chk_sci(1'b1, "R8 fixed enabled");
        @(negedge clk); fixed_sts = '0; fixed_en = '0;
        // R10 out-of-range index (300 aliases processor 44, byte 5 bit 4)
        evt(300, 1'b1);
        rd(16'hAF05, 8'h00, "R10 bitmap");
        rd(16'hAFE0, 8'h00, "R10 status");
        // R11 clear and event in same cycle
        @(negedge clk);
        io_addr = 16'hAFE0; io_wdata = 8'h04; io_wr = 1'b1;
        plug_valid = 1'b1; plug_index = 9'd9; plug_add = 1'b0;
        @(negedge clk);
        io_wr = 1'b0; plug_valid = 1'b0;
        rd(16'hAFE0, 8'h04, "R11 set wins");
        rd(16'hAF01, 8'h1D, "R4 remove 9");
        // R2 / R12 reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(16'hAF01, 8'h1F, "R2 refill");
        rd(16'hAF02, 8'h00, "R2 refill clear");
        rd(16'hAF1F, 8'h00, "R2 refill top");
        rd(16'hAFE0, 8'h00, "R12 status");
        rd(16'hAFE1, 8'h00, "R12 enable");
        chk_sci(1'b0, "R12 sci");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule